// File: doc/BRIEF.md
# Fovea Relocation Address Translator

This block sits on an address-event stream between a small pixel sensor and the router that maps events onto a bank of integrating neurons. Each event names one sensor pixel by column and row. The sensor is 80 columns by 60 rows. The router works on a 128 by 128 virtual field, in which a fixed high-acuity region is laid out. The block adds a programmable column offset and a separate row offset to every event. It then packs the result into a 14-bit virtual address. Changing the two offsets slides the sensor image under the fixed high-acuity region. The region therefore moves with no rewrite of the routing memory.

A small configuration port writes the offsets into holding registers. A separate apply command copies both holding values into the working pair together. The copy happens only in a cycle in which no event is taken, so every event is translated with one consistent pair. Offsets are clamped so that a translated address always stays inside the field. Events whose coordinates lie outside the sensor are consumed and dropped, and they raise a sticky error flag. The stream has one register of latency, and output backpressure reaches the input in the same cycle.

Top module: `fovea_xlate_top`

## Requirements
- R1: The output address is 14 bits wide. Bits 13:7 hold the translated row and bits 6:0 hold the translated column. With both working offsets at zero, pixel (x, y) maps to y*128 + x.
- R2: The translated column is the input column plus the working column offset. The translated row is the input row plus the working row offset.
- R3: The configuration select code decides what a write does. Code 0 writes the column holding register and code 1 writes the row holding register. Code 2 requests an apply. Code 3 does nothing. A column value above 48 is stored as 48, and a row value above 68 is stored as 68.
- R4: Writing a holding register does not change the translation of any event until an apply takes effect.
- R5: An apply request issued in cycle n is pending from cycle n+1 onward. It copies both holding registers into the working pair at the first edge from cycle n+1 on at which no input event is accepted. Events accepted before that edge use the old pair.
- R6: An accepted event with column of 80 or more, or row of 60 or more, produces no output. It sets the error flag, which stays set until reset.
- R7: A valid event accepted at one clock edge appears on the output from the next edge, and it stays until the output handshake completes.
- R8: Input ready is low exactly when an output is valid and the output side is not ready. While stalled, the output address holds steady.
- R9: After reset, the output is not valid, the error flag is clear and both working and holding offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input event present |
| inReady | output | 1 | Block can take an event |
| inX | input | 7 | Sensor column |
| inY | input | 6 | Sensor row |
| outValid | output | 1 | Translated event present |
| outReady | input | 1 | Downstream takes the event |
| outAddr | output | 14 | Virtual address {row, column} |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 column offset, 1 row offset, 2 apply, 3 none |
| cfgData | input | 7 | Offset value, clamped on write |
| errFlag | output | 1 | Sticky out-of-sensor event flag |

## Verification
On every cycle, the embedded assertions check several properties. The working offsets must stay within their clamp bounds. Every translated coordinate must lie inside the field. The working pair may change only on an apply strobe. A stalled output must hold its address. An accepted good event must produce an output on the next cycle, a dropped event must produce none, and the error flag must stay set once raised. Only the bench's scenarios can show the rest. These cover the exact arithmetic and packing of addresses, the clamped values reaching the output, apply requests that wait through back-to-back events, and holding-register writes that leave the translation alone. The bench's cycle model checks all of these under random stalls and random configuration traffic.

// File: rtl/fovea_pkg.sv
package fovea_pkg;
  typedef struct packed {
    logic loadOut;
    logic dropEvt;
    logic applyOffs;
  } foveaStrobes_t;

  typedef enum logic [1:0] {
    CFG_OFF_X = 2'd0,
    CFG_OFF_Y = 2'd1,
    CFG_APPLY = 2'd2,
    CFG_NONE  = 2'd3
  } cfgSel_e;
endpackage

// File: rtl/fovea_ctrl.sv
module fovea_ctrl
  import fovea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          inRange,
  input  logic          outReady,
  input  logic          cfgApplyReq,
  output logic          inReady,
  output logic          outValid,
  output logic          errFlag,
  output foveaStrobes_t strb
);
  logic accept;
  logic applyPend;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strb.loadOut   = accept && inRange;
    strb.dropEvt   = accept && !inRange;
    strb.applyOffs = applyPend && !accept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      errFlag   <= 1'b0;
      applyPend <= 1'b0;
    end else begin
      if (strb.loadOut)   outValid <= 1'b1;
      else if (outReady)  outValid <= 1'b0;
      if (strb.dropEvt)   errFlag <= 1'b1;
      if (cfgApplyReq)         applyPend <= 1'b1;
      else if (strb.applyOffs) applyPend <= 1'b0;
    end
  end

  // R6: the flag never clears on its own
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
  // R6: a dropped event leaves no output behind
  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dropEvt |=> !outValid);
  // R7: a loaded event is visible on the next cycle
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadOut |=> outValid);
endmodule

// File: rtl/fovea_datapath.sv
module fovea_datapath
  import fovea_pkg::*;
#(
  parameter int SENSOR_W   = 80,
  parameter int SENSOR_H   = 60,
  parameter int FIELD_BITS = 7,
  localparam int XW = $clog2(SENSOR_W),
  localparam int YW = $clog2(SENSOR_H)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  foveaStrobes_t           strb,
  input  logic [XW-1:0]           inX,
  input  logic [YW-1:0]           inY,
  input  logic                    cfgWrEn,
  input  logic [1:0]              cfgSel,
  input  logic [FIELD_BITS-1:0]   cfgData,
  output logic                    inRange,
  output logic [2*FIELD_BITS-1:0] outAddr
);
  localparam int FB = FIELD_BITS;
  localparam int FIELD = 2 ** FB;
  localparam logic [FB-1:0] OFFX_MAX = FB'(FIELD - SENSOR_W);
  localparam logic [FB-1:0] OFFY_MAX = FB'(FIELD - SENSOR_H);
  localparam logic [XW:0] X_LIM = (XW+1)'(SENSOR_W);
  localparam logic [YW:0] Y_LIM = (YW+1)'(SENSOR_H);

  logic [FB-1:0] holdOffX, holdOffY;
  logic [FB-1:0] actOffX,  actOffY;
  logic [FB-1:0] sumX, sumY;
  logic [FB-1:0] clampX, clampY;

  assign inRange = ({1'b0, inX} < X_LIM) && ({1'b0, inY} < Y_LIM);
  assign clampX  = (cfgData > OFFX_MAX) ? OFFX_MAX : cfgData;
  assign clampY  = (cfgData > OFFY_MAX) ? OFFY_MAX : cfgData;
  assign sumX    = FB'(inX) + actOffX;
  assign sumY    = FB'(inY) + actOffY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdOffX <= '0;
      holdOffY <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel == CFG_OFF_X) holdOffX <= clampX;
      if (cfgSel == CFG_OFF_Y) holdOffY <= clampY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actOffX <= '0;
      actOffY <= '0;
    end else if (strb.applyOffs) begin
      actOffX <= holdOffX;
      actOffY <= holdOffY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            outAddr <= '0;
    else if (strb.loadOut) outAddr <= {sumY, sumX};
  end

  // R3: working offsets never exceed their bounds
  p_off_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (actOffX <= OFFX_MAX) && (actOffY <= OFFY_MAX));
  // R2: a translated coordinate never wraps past the field edge
  p_in_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadOut |-> ((FB+1)'(inX) + {1'b0, actOffX} < (FB+1)'(FIELD)) &&
                     ((FB+1)'(inY) + {1'b0, actOffY} < (FB+1)'(FIELD)));
  // R5: working pair changes only on an apply strobe
  p_apply_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(actOffX) || !$stable(actOffY)) |-> $past(strb.applyOffs));
endmodule

// File: rtl/fovea_xlate_top.sv
module fovea_xlate_top
  import fovea_pkg::*;
#(
  parameter int SENSOR_W   = 80,
  parameter int SENSOR_H   = 60,
  parameter int FIELD_BITS = 7
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                inValid,
  output logic                                inReady,
  input  logic [$clog2(SENSOR_W)-1:0]         inX,
  input  logic [$clog2(SENSOR_H)-1:0]         inY,
  output logic                                outValid,
  input  logic                                outReady,
  output logic [2*FIELD_BITS-1:0]             outAddr,
  input  logic                                cfgWrEn,
  input  logic [1:0]                          cfgSel,
  input  logic [FIELD_BITS-1:0]               cfgData,
  output logic                                errFlag
);
  foveaStrobes_t strb;
  logic inRange;
  logic cfgApplyReq;

  assign cfgApplyReq = cfgWrEn && (cfgSel == CFG_APPLY);

  fovea_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inRange(inRange),
    .outReady(outReady), .cfgApplyReq(cfgApplyReq), .inReady(inReady),
    .outValid(outValid), .errFlag(errFlag), .strb(strb)
  );

  fovea_datapath #(
    .SENSOR_W(SENSOR_W), .SENSOR_H(SENSOR_H), .FIELD_BITS(FIELD_BITS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inX(inX), .inY(inY),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .inRange(inRange), .outAddr(outAddr)
  );

  // R8: a stalled output holds its value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outAddr)));
  // R8: no event enters while the output is stalled
  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: tb/fovea_xlate_top_tb.sv
module fovea_xlate_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, outReady = 1'b1, cfgWrEn = 1'b0;
  logic [6:0] inX = '0;
  logic [5:0] inY = '0;
  logic [1:0] cfgSel = 2'd3;
  logic [6:0] cfgData = '0;
  logic inReady, outValid, errFlag;
  logic [13:0] outAddr;

  int checks = 0, errors = 0;
  bit modelOn = 0;

  // reference model state
  bit mValid = 0, mErr = 0, mPend = 0;
  int mAddr = 0, hX = 0, hY = 0, aX = 0, aY = 0;

  always #5 clk = ~clk;

  fovea_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mValid = 0; mErr = 0; mPend = 0; mAddr = 0;
      hX = 0; hY = 0; aX = 0; aY = 0;
    end else begin
      bit rdy, acc, good;
      int oldHX, oldHY;
      rdy = !mValid || outReady;
      acc = inValid && rdy;
      good = (inX < 80) && (inY < 60);
      oldHX = hX; oldHY = hY;
      if (acc && good) begin
        mValid = 1;
        mAddr = (int'(inY) + aY) * 128 + (int'(inX) + aX);
      end else if (outReady) mValid = 0;
      if (acc && !good) mErr = 1;
      if (mPend && !acc) begin aX = oldHX; aY = oldHY; end
      if (cfgWrEn && cfgSel == 2'd2) mPend = 1;
      else if (mPend && !acc) mPend = 0;
      if (cfgWrEn && cfgSel == 2'd0) hX = (cfgData > 48) ? 48 : int'(cfgData);
      if (cfgWrEn && cfgSel == 2'd1) hY = (cfgData > 68) ? 68 : int'(cfgData);
    end
  end

  always @(negedge clk) begin
    #1;
    if (modelOn && rst_n) begin
      chk(outValid == mValid, "R7 outValid", outValid, mValid);
      if (mValid) chk(int'(outAddr) == mAddr, "R1/R2 outAddr", outAddr, mAddr);
      chk(inReady == (!mValid || outReady), "R8 inReady", inReady, !mValid || outReady);
      chk(errFlag == mErr, "R6 errFlag", errFlag, mErr);
    end
  end

  task automatic cyc(input bit v, input int x, input int y,
                     input bit wr, input int sel, input int d);
    @(negedge clk);
    inValid = v; inX = 7'(x); inY = 6'(y);
    cfgWrEn = wr; cfgSel = 2'(sel); cfgData = 7'(d);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 3, 0); endtask

  task automatic expectAddr(input int exp, input string req);
    idle();
    #2;
    chk(outValid == 1'b1, req, outValid, 1);
    chk(int'(outAddr) == exp, req, outAddr, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(outValid == 0, "R9 outValid after reset", outValid, 0);
    chk(errFlag == 0, "R9 errFlag after reset", errFlag, 0);
    chk(inReady == 1, "R9 inReady after reset", inReady, 1);
    modelOn = 1;

    // R1: zero offsets, identity packing
    cyc(1, 5, 7, 0, 3, 0);
    expectAddr(7*128 + 5, "R1 zero-offset packing");

    // R4: holding writes without apply do not move the map
    cyc(0, 0, 0, 1, 0, 10);
    cyc(0, 0, 0, 1, 1, 20);
    cyc(1, 1, 1, 0, 3, 0);
    expectAddr(129, "R4 holding write ignored");
    // code 3 has no effect (R3)
    cyc(0, 0, 0, 1, 3, 99);
    // R2: apply then translate
    cyc(0, 0, 0, 1, 2, 0);
    idle();
    cyc(1, 1, 1, 0, 3, 0);
    expectAddr(21*128 + 11, "R2 offset add");

    // R3: clamping to the field edge
    cyc(0, 0, 0, 1, 0, 100);
    cyc(0, 0, 0, 1, 1, 127);
    cyc(0, 0, 0, 1, 2, 0);
    idle();
    cyc(1, 79, 59, 0, 3, 0);
    expectAddr(16383, "R3 clamped corner");

    // R5: apply deferred while events stream back to back
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0);
    cyc(1, 0, 0, 1, 2, 0);
    cyc(1, 0, 0, 0, 3, 0);
    #2;
    chk(int'(outAddr) == 68*128 + 48, "R5 old pair during stream", outAddr, 68*128 + 48);
    cyc(1, 2, 3, 0, 3, 0);
    #2;
    chk(int'(outAddr) == 68*128 + 48, "R5 old pair second event", outAddr, 68*128 + 48);
    expectAddr(71*128 + 50, "R5 old pair third event");
    cyc(1, 2, 3, 0, 3, 0);
    expectAddr(3*128 + 2, "R5 new pair after gap");

    // R6: out-of-sensor events are dropped
    cyc(1, 80, 0, 0, 3, 0);
    idle();
    #2;
    chk(outValid == 0, "R6 dropped column", outValid, 0);
    chk(errFlag == 1, "R6 flag set", errFlag, 1);
    cyc(1, 0, 60, 0, 3, 0);
    idle();
    #2;
    chk(outValid == 0, "R6 dropped row", outValid, 0);

    // R8: stall holds the output
    cyc(1, 9, 9, 0, 3, 0);
    @(negedge clk);
    inValid = 1; inX = 1; inY = 1; outReady = 0;
    #2;
    chk(inReady == 0, "R8 ready low on stall", inReady, 0);
    chk(int'(outAddr) == 9*128 + 9, "R8 held address", outAddr, 9*128 + 9);
    @(negedge clk);
    outReady = 1; inValid = 0;
    idle();

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      inValid = ($urandom_range(0, 3) != 0);
      inX = 7'($urandom_range(0, 85));
      inY = 6'($urandom_range(0, 63));
      outReady = ($urandom_range(0, 3) != 0);
      cfgWrEn = ($urandom_range(0, 7) == 0);
      cfgSel = 2'($urandom_range(0, 3));
      cfgData = 7'($urandom_range(0, 127));
    end
    @(negedge clk);
    inValid = 0; cfgWrEn = 0; outReady = 1;
    repeat (3) @(negedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule